// File: doc/BRIEF.md
# Serial Audio Output Port

This block serialises stereo PCM samples onto a single data line. It does not generate any clocks. The bit clock, the left/right framing clock and an optional word clock come from outside and are oversampled by the block's system clock. The block finds their edges and drives the data line in step with them. A producer hands over left/right sample pairs through a ready/valid handshake. A pair waits in a one-entry holding slot until the next left word begins, so both channels of a pair always go out in the same frame.

Three strap inputs set the framing:
- **Polarity strap:** selects which bit clock edge launches data and which edge a receiver captures on.
- **Trigger strap:** selects whether every left/right clock transition starts a word, or only a rising word clock edge does.
- **Delay strap:** inserts one extra bit clock between the start event and the MSB, as I2S-style links require.

A mute input forces the data line to zero, which is midscale for two's complement samples. If no new pair is waiting when a left word starts, the port resends the previous pair and raises a sticky underrun flag.

Top module: `serial_audio_tx`

## Requirements
- R1: With `strap_inv_bclk` low, `sdata` changes only after a falling `bclk` edge and is valid at the rising edge. With it high, the roles of the two edges are swapped.
- R2: With `strap_lr_trig` high, every transition of `lrclk` (rising or falling) starts a new word at the same launch edge, even if the previous word has not finished.
- R3: With `strap_lr_trig` low, only a rising `wclk` edge starts a word, and `lrclk` transitions do not restart the shifter.
- R4: With `strap_msb_delay` high, the launch edge of the start event drives 0 and the MSB follows one bit clock later. With it low, the MSB is driven at the start event's launch edge. This holds in both trigger modes.
- R5: A word goes out MSB first and is SAMPLE_W bits long. Every launch edge after the LSB, until the next start, drives 0.
- R6: A word that starts while `lrclk` is high carries the left sample, and one that starts while `lrclk` is low carries the right sample. The pair is taken at the left-word start.
- R7: While `mute` is high, `sdata` is 0.
- R8: `in_ready` is high exactly when the holding slot is empty. A pair is accepted on a cycle with `in_valid` and `in_ready` both high. While the slot is full, `in_valid` has no effect. The slot empties at the next left-word start.
- R9: At a left-word start with an empty slot, the previously sent pair (zero after reset) is sent again and `underrun` goes high. It stays high until `rst`.
- R10: Strap values are taken only when a word starts. A change in the middle of a word does not affect that word.
- R11: After synchronous reset, `sdata` is 0, `in_ready` is 1 and `underrun` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial clocks |
| rst | input | 1 | Synchronous active-high reset |
| bclk | input | 1 | Bit clock |
| lrclk | input | 1 | Left/right framing clock, high = left |
| wclk | input | 1 | Word clock, rising edge starts a word in word-clock mode |
| strap_inv_bclk | input | 1 | 0: launch on falling bclk; 1: launch on rising bclk |
| strap_lr_trig | input | 1 | 1: lrclk transitions start words; 0: wclk rising edge does |
| strap_msb_delay | input | 1 | 1: MSB one bit clock after the start event |
| mute | input | 1 | Forces zero output |
| in_valid | input | 1 | Sample pair valid |
| in_ready | output | 1 | Holding slot empty |
| in_left | input | SAMPLE_W | Left sample |
| in_right | input | SAMPLE_W | Right sample |
| sdata | output | 1 | Serial data |
| underrun | output | 1 | Sticky: a pair was repeated |

## Verification
Two situations are hard to reach from the ports, because a normal frame hides them. The first is a strap change in the middle of a word. The second is an `lrclk` toggle that must be ignored in word-clock mode.

For the first case, the bench raises the delay strap halfway through the left word. It then expects the left word undelayed and the right word delayed.

For the second case, the bench shortens each channel slot to half a sample and pulses `wclk` only for the left word. If the `lrclk` toggle were wrongly treated as a start, the right slot would carry right-sample MSBs. Because it is ignored, the right slot shows the lower half of the left sample instead.

// File: rtl/serial_audio_tx_pkg.sv
package serial_audio_tx_pkg;

    typedef struct packed {
        logic inv_bclk;
        logic lr_trig;
        logic msb_delay;
    } strap_t;

    typedef struct packed {
        logic   bclk_prev;
        logic   lr_prev;
        logic   wclk_prev;
        logic   pend;
        strap_t straps;
    } timing_state_t;

endpackage

// File: rtl/sat_sync.sv
module sat_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) stage_q[0] <= d;
        end else begin : g_rest
            always_ff @(posedge clk) stage_q[g] <= stage_q[g-1];
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/sat_frame_timing.sv
module sat_frame_timing
    import serial_audio_tx_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   bclk_s,
    input  logic   lr_s,
    input  logic   wclk_s,
    input  strap_t straps_in,
    output logic   launch,
    output logic   word_start,
    output logic   left_start,
    output strap_t straps_q
);
    timing_state_t cur_q, nxt_d;
    logic b_rise, b_fall, lr_edge, w_rise, evt;

    always_comb begin
        b_rise  = bclk_s & ~cur_q.bclk_prev;
        b_fall  = ~bclk_s & cur_q.bclk_prev;
        lr_edge = lr_s ^ cur_q.lr_prev;
        w_rise  = wclk_s & ~cur_q.wclk_prev;
        launch  = cur_q.straps.inv_bclk ? b_rise : b_fall;
        evt     = cur_q.straps.lr_trig ? lr_edge : w_rise;
        word_start = launch & (cur_q.pend | evt);
        left_start = word_start & lr_s;

        nxt_d           = cur_q;
        nxt_d.bclk_prev = bclk_s;
        nxt_d.lr_prev   = lr_s;
        nxt_d.wclk_prev = wclk_s;
        nxt_d.pend      = launch ? 1'b0 : (cur_q.pend | evt);
        if (word_start) begin
            nxt_d.straps = straps_in;
        end
        if (rst) begin
            nxt_d.pend   = 1'b0;
            nxt_d.straps = straps_in;
        end
    end

    always_ff @(posedge clk) cur_q <= nxt_d;

    assign straps_q = cur_q.straps;
endmodule

// File: rtl/sat_sample_store.sv
module sat_sample_store #(
    parameter int SAMPLE_W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic [SAMPLE_W-1:0] in_left,
    input  logic [SAMPLE_W-1:0] in_right,
    input  logic                left_start,
    output logic                in_ready,
    output logic [SAMPLE_W-1:0] pair_l,
    output logic [SAMPLE_W-1:0] pair_r,
    output logic                underrun
);
    typedef struct packed {
        logic                hold_v;
        logic [SAMPLE_W-1:0] hold_l;
        logic [SAMPLE_W-1:0] hold_r;
        logic [SAMPLE_W-1:0] cur_l;
        logic [SAMPLE_W-1:0] cur_r;
        logic                under;
    } store_t;

    store_t st_q, st_d;
    logic   accept;

    always_comb begin
        accept = in_valid & ~st_q.hold_v;
        st_d   = st_q;
        if (left_start) begin
            if (st_q.hold_v) begin
                st_d.cur_l  = st_q.hold_l;
                st_d.cur_r  = st_q.hold_r;
                st_d.hold_v = 1'b0;
            end else begin
                st_d.under = 1'b1;
            end
        end
        if (accept) begin
            st_d.hold_v = 1'b1;
            st_d.hold_l = in_left;
            st_d.hold_r = in_right;
        end
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) st_q <= st_d;

    assign in_ready = ~st_q.hold_v;
    assign pair_l   = (left_start && st_q.hold_v) ? st_q.hold_l : st_q.cur_l;
    assign pair_r   = (left_start && st_q.hold_v) ? st_q.hold_r : st_q.cur_r;
    assign underrun = st_q.under;
endmodule

// File: rtl/sat_shifter.sv
module sat_shifter #(
    parameter int SAMPLE_W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                launch,
    input  logic                word_start,
    input  logic                is_left,
    input  logic                dly_new,
    input  logic [SAMPLE_W-1:0] pair_l,
    input  logic [SAMPLE_W-1:0] pair_r,
    input  logic                mute_s,
    output logic                bit_v,
    output logic                sdata
);
    typedef struct packed {
        logic [SAMPLE_W-1:0] sr;
        logic                bit_v;
        logic                sdata;
    } shift_t;

    shift_t sh_q, sh_d;
    logic [SAMPLE_W-1:0] sel;

    always_comb begin
        sel  = is_left ? pair_l : pair_r;
        sh_d = sh_q;
        if (launch) begin
            if (word_start) begin
                if (dly_new) begin
                    sh_d.bit_v = 1'b0;
                    sh_d.sr    = sel;
                end else begin
                    sh_d.bit_v = sel[SAMPLE_W-1];
                    sh_d.sr    = {sel[SAMPLE_W-2:0], 1'b0};
                end
            end else begin
                sh_d.bit_v = sh_q.sr[SAMPLE_W-1];
                sh_d.sr    = {sh_q.sr[SAMPLE_W-2:0], 1'b0};
            end
        end
        sh_d.sdata = sh_q.bit_v & ~mute_s;
        if (rst) begin
            sh_d = '0;
        end
    end

    always_ff @(posedge clk) sh_q <= sh_d;

    assign bit_v = sh_q.bit_v;
    assign sdata = sh_q.sdata;
endmodule

// File: rtl/serial_audio_tx.sv
module serial_audio_tx
    import serial_audio_tx_pkg::*;
#(
    parameter int SAMPLE_W    = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bclk,
    input  logic                lrclk,
    input  logic                wclk,
    input  logic                strap_inv_bclk,
    input  logic                strap_lr_trig,
    input  logic                strap_msb_delay,
    input  logic                mute,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [SAMPLE_W-1:0] in_left,
    input  logic [SAMPLE_W-1:0] in_right,
    output logic                sdata,
    output logic                underrun
);
    localparam int SYNC_W = 7;

    logic [SYNC_W-1:0] raw_in, sync_out;
    strap_t straps_s, straps_cur;
    logic bclk_s, lr_s, wclk_s, mute_s;
    logic launch, word_start, left_start, bit_v;
    logic [SAMPLE_W-1:0] pair_l, pair_r;

    assign raw_in = {strap_inv_bclk, strap_lr_trig, strap_msb_delay, mute, wclk, lrclk, bclk};

    sat_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .d   (raw_in),
        .q   (sync_out)
    );

    assign bclk_s   = sync_out[0];
    assign lr_s     = sync_out[1];
    assign wclk_s   = sync_out[2];
    assign mute_s   = sync_out[3];
    assign straps_s = sync_out[6:4];

    sat_frame_timing u_timing (
        .clk        (clk),
        .rst        (rst),
        .bclk_s     (bclk_s),
        .lr_s       (lr_s),
        .wclk_s     (wclk_s),
        .straps_in  (straps_s),
        .launch     (launch),
        .word_start (word_start),
        .left_start (left_start),
        .straps_q   (straps_cur)
    );

    sat_sample_store #(.SAMPLE_W(SAMPLE_W)) u_store (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_left    (in_left),
        .in_right   (in_right),
        .left_start (left_start),
        .in_ready   (in_ready),
        .pair_l     (pair_l),
        .pair_r     (pair_r),
        .underrun   (underrun)
    );

    sat_shifter #(.SAMPLE_W(SAMPLE_W)) u_shift (
        .clk        (clk),
        .rst        (rst),
        .launch     (launch),
        .word_start (word_start),
        .is_left    (lr_s),
        .dly_new    (straps_s.msb_delay),
        .pair_l     (pair_l),
        .pair_r     (pair_r),
        .mute_s     (mute_s),
        .bit_v      (bit_v),
        .sdata      (sdata)
    );
endmodule

// File: rtl/serial_audio_tx_checker.sv
module serial_audio_tx_checker (
    input logic       clk,
    input logic       rst,
    input logic       in_valid,
    input logic       in_ready,
    input logic       underrun,
    input logic       sdata,
    input logic       mute_s,
    input logic       launch,
    input logic       bit_v,
    input logic       word_start,
    input logic       left_start,
    input logic [2:0] straps_q
);
    p_bit_holds_r1: assert property (@(posedge clk) disable iff (rst)
        !launch |=> $stable(bit_v));

    p_mute_zero_r7: assert property (@(posedge clk) disable iff (rst)
        mute_s |=> !sdata);

    p_ready_drop_r8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> !in_ready);

    p_ready_rise_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(in_ready) |-> $past(left_start));

    p_underrun_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        underrun |=> underrun);

    p_underrun_cause_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(underrun) |-> $past(left_start && in_ready));

    p_straps_word_r10: assert property (@(posedge clk) disable iff (rst)
        !word_start |=> $stable(straps_q));
endmodule

bind serial_audio_tx serial_audio_tx_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .underrun   (underrun),
    .sdata      (sdata),
    .mute_s     (mute_s),
    .launch     (launch),
    .bit_v      (bit_v),
    .word_start (word_start),
    .left_start (left_start),
    .straps_q   (straps_cur)
);

// File: tb/test_serial_audio_tx.sv
`timescale 1ns/1ps
module test_serial_audio_tx;
    localparam int SW   = 16;
    localparam int HALF = 8;
    localparam int NB   = SW + 2;

    typedef struct packed {
        bit          pol;
        bit          trig;
        bit          dly;
        bit          mu;
        logic [15:0] l;
        logic [15:0] r;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{1'b0, 1'b1, 1'b0, 1'b0, 16'hA5C3, 16'h5A3C},
        '{1'b0, 1'b1, 1'b1, 1'b0, 16'h8001, 16'h7FFE},
        '{1'b1, 1'b1, 1'b0, 1'b0, 16'h1234, 16'hFEDC},
        '{1'b1, 1'b0, 1'b1, 1'b0, 16'hF00F, 16'h0FF0},
        '{1'b0, 1'b0, 1'b0, 1'b0, 16'hCAFE, 16'hBEEF},
        '{1'b1, 1'b1, 1'b1, 1'b1, 16'hFFFF, 16'hFFFF}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bclk = 1'b1, lrclk = 1'b0, wclk = 1'b0;
    logic strap_inv_bclk = 1'b0, strap_lr_trig = 1'b1, strap_msb_delay = 1'b0;
    logic mute = 1'b0, in_valid = 1'b0;
    logic [SW-1:0] in_left = '0, in_right = '0;
    logic in_ready, sdata, underrun;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    serial_audio_tx i_serial_audio_tx (
        .clk             (clk),
        .rst             (rst),
        .bclk            (bclk),
        .lrclk           (lrclk),
        .wclk            (wclk),
        .strap_inv_bclk  (strap_inv_bclk),
        .strap_lr_trig   (strap_lr_trig),
        .strap_msb_delay (strap_msb_delay),
        .mute            (mute),
        .in_valid        (in_valid),
        .in_ready        (in_ready),
        .in_left         (in_left),
        .in_right        (in_right),
        .sdata           (sdata),
        .underrun        (underrun)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [NB-1:0] exp_bits(input logic [SW-1:0] w, input bit dly,
                                               input int offset, input int nb, input bit mu);
        logic [NB-1:0] r = '0;
        for (int b = 0; b < nb; b++) begin
            int idx = offset + b - (dly ? 1 : 0);
            if (!mu && idx >= 0 && idx < SW) r[NB-1-b] = w[SW-1-idx];
        end
        return r;
    endfunction

    task automatic do_reset(input bit pol, input bit trig, input bit dly, input bit mu);
        @(negedge clk);
        strap_inv_bclk  = pol;
        strap_lr_trig   = trig;
        strap_msb_delay = dly;
        mute  = mu;
        bclk  = pol ? 1'b0 : 1'b1;
        lrclk = 1'b0;
        wclk  = 1'b0;
        rst   = 1'b1;
        repeat (10) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic push(input logic [SW-1:0] l, input logic [SW-1:0] r);
        in_valid = 1'b1;
        in_left  = l;
        in_right = r;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic run_frame(input int nb, input bit rpulse, input bit mid_dly,
                             output logic [NB-1:0] gl, output logic [NB-1:0] gr);
        logic lv;
        lv = strap_inv_bclk;
        gl = '0;
        gr = '0;
        for (int ch = 0; ch < 2; ch++) begin
            for (int b = 0; b < nb; b++) begin
                bclk = lv;
                if (b == 0) begin
                    lrclk = (ch == 0);
                    if (ch == 0 || rpulse) wclk = 1'b1;
                end
                if (b == 1) wclk = 1'b0;
                if (mid_dly && ch == 0 && b == 4) strap_msb_delay = 1'b1;
                repeat (HALF) @(negedge clk);
                if (ch == 0) gl[NB-1-b] = sdata;
                else         gr[NB-1-b] = sdata;
                bclk = ~lv;
                repeat (HALF) @(negedge clk);
            end
        end
    endtask

    initial begin
        #(4 * 200000);
        checks++;
        fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [NB-1:0] gl, gr;

        do_reset(1'b0, 1'b1, 1'b0, 1'b0);
        check("R11 sdata after reset", 64'(sdata), 64'd0);
        check("R11 in_ready after reset", 64'(in_ready), 64'd1);
        check("R11 underrun after reset", 64'(underrun), 64'd0);

        // R1 R2 R3 R4 R5 R6 R7: table of strap settings and sample pairs
        for (int v = 0; v < 6; v++) begin
            do_reset(VECS[v].pol, VECS[v].trig, VECS[v].dly, VECS[v].mu);
            push(VECS[v].l, VECS[v].r);
            check("R8 ready low after accept", 64'(in_ready), 64'd0);
            run_frame(NB, 1'b1, 1'b0, gl, gr);
            check("R1 R4 R5 R6 R7 left word", 64'(gl),
                  64'(exp_bits(VECS[v].l, VECS[v].dly, 0, NB, VECS[v].mu)));
            check("R1 R4 R5 R6 R7 right word", 64'(gr),
                  64'(exp_bits(VECS[v].r, VECS[v].dly, 0, NB, VECS[v].mu)));
        end

        // R9: underrun repeats previous pair, sticky until reset
        do_reset(1'b0, 1'b1, 1'b0, 1'b0);
        run_frame(NB, 1'b1, 1'b0, gl, gr);
        check("R9 empty start sends zero pair", 64'({gl, gr}), 64'd0);
        check("R9 underrun set", 64'(underrun), 64'd1);
        push(16'h6B29, 16'h94D6);
        run_frame(NB, 1'b1, 1'b0, gl, gr);
        check("R9 new pair after underrun", 64'({gl, gr}),
              64'({exp_bits(16'h6B29, 1'b0, 0, NB, 1'b0), exp_bits(16'h94D6, 1'b0, 0, NB, 1'b0)}));
        check("R9 underrun sticky", 64'(underrun), 64'd1);
        check("R8 ready after left start", 64'(in_ready), 64'd1);
        run_frame(NB, 1'b1, 1'b0, gl, gr);
        check("R9 pair repeated", 64'({gl, gr}),
              64'({exp_bits(16'h6B29, 1'b0, 0, NB, 1'b0), exp_bits(16'h94D6, 1'b0, 0, NB, 1'b0)}));
        do_reset(1'b0, 1'b1, 1'b0, 1'b0);
        check("R9 reset clears underrun", 64'(underrun), 64'd0);

        // R8: a second pair offered while the slot is full has no effect
        push(16'h1357, 16'h2468);
        in_valid = 1'b1;
        in_left  = 16'hDEAD;
        in_right = 16'hBEEF;
        repeat (20) @(negedge clk);
        in_valid = 1'b0;
        check("R8 ready stays low while full", 64'(in_ready), 64'd0);
        run_frame(NB, 1'b1, 1'b0, gl, gr);
        check("R8 full slot ignores valid", 64'({gl, gr}),
              64'({exp_bits(16'h1357, 1'b0, 0, NB, 1'b0), exp_bits(16'h2468, 1'b0, 0, NB, 1'b0)}));
        check("R9 no underrun when fed", 64'(underrun), 64'd0);

        // R2: short slots, every lrclk transition restarts the word
        do_reset(1'b0, 1'b1, 1'b0, 1'b0);
        push(16'hC3A5, 16'h3C5A);
        run_frame(8, 1'b1, 1'b0, gl, gr);
        check("R2 short slot left", 64'(gl), 64'(exp_bits(16'hC3A5, 1'b0, 0, 8, 1'b0)));
        check("R2 short slot right restarts", 64'(gr), 64'(exp_bits(16'h3C5A, 1'b0, 0, 8, 1'b0)));

        // R3: word-clock mode ignores the lrclk transition without a wclk edge
        do_reset(1'b0, 1'b0, 1'b0, 1'b0);
        push(16'hC3A5, 16'h3C5A);
        run_frame(8, 1'b0, 1'b0, gl, gr);
        check("R3 left slot", 64'(gl), 64'(exp_bits(16'hC3A5, 1'b0, 0, 8, 1'b0)));
        check("R3 lrclk toggle ignored", 64'(gr), 64'(exp_bits(16'hC3A5, 1'b0, 8, 8, 1'b0)));

        // R10: delay strap raised mid-left-word applies from the right word on
        do_reset(1'b0, 1'b1, 1'b0, 1'b0);
        push(16'h9A6F, 16'h65F0);
        run_frame(NB, 1'b1, 1'b1, gl, gr);
        check("R10 word in flight unchanged", 64'(gl), 64'(exp_bits(16'h9A6F, 1'b0, 0, NB, 1'b0)));
        check("R10 next word uses new strap", 64'(gr), 64'(exp_bits(16'h65F0, 1'b1, 0, NB, 1'b0)));

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule